// File: doc/BRIEF.md
# GPIO Port Core with Latched, Maskable Interrupts

This block is the parallel-port core that sits behind a serial register interface in an I/O expander. Software reaches it through a simple register bus of address, write data, write strobe, read strobe and registered read data. It holds the output value, polarity, direction, pull-control, drive-strength, input-latch, interrupt-mask and output-mode settings. It synchronizes the pins, applies per-bit polarity and presents the Input Port value.

A change on an unmasked input raises an interrupt. The interrupt is a pull-low enable that models an open-drain, active-low line. A read-only status register names the bits that caused it. Reading the Input Port register acknowledges everything. It clears the status and the interrupt, makes the value just returned the new reference for change detection, and releases latched bits so that they follow the live pins again. Bits with latching enabled keep the first changed value until that read. All masks are set after reset, so bring-up is free of spurious interrupts.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every pin is an input (`pin_oe` all zero), `pin_out` is zero, the interrupt is released, DIR (addr 3) and MASK (addr 9) read all ones, and STATUS (addr 10) reads zero.
- R2: The registers OUT (1), POL (2), DIR (3), PULLEN (4), PULLSEL (5), DRVL (6), DRVH (7), LATCH (8) and MASK (9) read back what was written. MODE (11) keeps only bit 0, and unused addresses read zero.
- R3: The INPUT register (addr 0) returns the pins after a two-flop synchronizer, XOR-ed bit by bit with POL.
- R4: When an unmasked input differs from the reference captured at the last INPUT read, `irq_drive_low` rises on the third rising clock edge after the pin change.
- R5: A bit whose MASK bit is 1 never sets its STATUS bit and never raises the interrupt.
- R6: STATUS (addr 10) shows a 1 for each bit that caused the pending interrupt. It stays set after the input returns to its old value, and writes to it are ignored.
- R7: A read of INPUT clears STATUS and releases the interrupt at the same clock edge that returns the data.
- R8: For a bit with LATCH set, the first change after the last INPUT read is held in INPUT until INPUT is read, even if the pin returns. The following read shows the live value again.
- R9: For a bit with LATCH clear, INPUT shows the live synchronized value.
- R10: With MODE bit 0 = 0 (push-pull), `pin_out` equals OUT and `pin_oe` equals the inverse of DIR (DIR 1 = input). Both are registered one cycle after the register write.
- R11: With MODE bit 0 = 1 (open-drain), `pin_out` is zero and `pin_oe` is 1 only where DIR is 0 and OUT is 0.
- R12: `rdata` changes only on a cycle with `rd_en` high and otherwise holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register address |
| wdata | input | WIDTH | Write data |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| rdata | output | WIDTH | Registered read data |
| pin_in | input | WIDTH | Asynchronous pin inputs |
| pin_out | output | WIDTH | Pin output value |
| pin_oe | output | WIDTH | Pin output enable |
| irq_drive_low | output | 1 | 1 pulls the active-low interrupt line low |

## Verification
The bench builds the core with WIDTH = 8 and SYNC_STAGES = 2. The eight bits leave room for masked, unmasked, latched and unlatched bits to change side by side in one test. With two synchronizer stages the three-edge latency from a pin change to the interrupt is exact, and the bench checks the cycle before and the cycle of assertion. Register round trips come from a vector table. Polarity, masking, latching, acknowledge and both drive modes are checked in directed sequences.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_INPUT   = 4'd0,
    A_OUTPUT  = 4'd1,
    A_POLAR   = 4'd2,
    A_DIR     = 4'd3,
    A_PULLEN  = 4'd4,
    A_PULLSEL = 4'd5,
    A_DRVL    = 4'd6,
    A_DRVH    = 4'd7,
    A_LATCH   = 4'd8,
    A_MASK    = 4'd9,
    A_STATUS  = 4'd10,
    A_MODE    = 4'd11
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  out_q,
  output logic [WIDTH-1:0]  pol_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  pullen_q,
  output logic [WIDTH-1:0]  pullsel_q,
  output logic [WIDTH-1:0]  drvl_q,
  output logic [WIDTH-1:0]  drvh_q,
  output logic [WIDTH-1:0]  latch_q,
  output logic [WIDTH-1:0]  mask_q,
  output logic              od_mode_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q     <= '0;
      pol_q     <= '0;
      dir_q     <= '1;
      pullen_q  <= '0;
      pullsel_q <= '0;
      drvl_q    <= '0;
      drvh_q    <= '0;
      latch_q   <= '0;
      mask_q    <= '1;
      od_mode_q <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        A_OUTPUT:  out_q     <= wdata;
        A_POLAR:   pol_q     <= wdata;
        A_DIR:     dir_q     <= wdata;
        A_PULLEN:  pullen_q  <= wdata;
        A_PULLSEL: pullsel_q <= wdata;
        A_DRVL:    drvl_q    <= wdata;
        A_DRVH:    drvh_q    <= wdata;
        A_LATCH:   latch_q   <= wdata;
        A_MASK:    mask_q    <= wdata;
        A_MODE:    od_mode_q <= wdata[0];
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] mask,
  input  logic [WIDTH-1:0] latch_en,
  input  logic             ack,
  output logic [WIDTH-1:0] port_val,
  output logic [WIDTH-1:0] status_q,
  output logic             irq_q
);
  logic [WIDTH-1:0] ref_q;
  logic [WIDTH-1:0] held_q;
  logic [WIDTH-1:0] hval_q;
  logic [WIDTH-1:0] diff;
  logic [WIDTH-1:0] cap;
  logic [WIDTH-1:0] status_nxt;

  assign port_val   = (held_q & hval_q) | (~held_q & live);
  assign diff       = live ^ ref_q;
  assign cap        = latch_en & diff & ~held_q;
  assign status_nxt = status_q | (diff & ~mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q    <= '0;
      held_q   <= '0;
      hval_q   <= '0;
      status_q <= '0;
      irq_q    <= 1'b0;
    end else if (ack) begin
      ref_q    <= port_val;
      held_q   <= '0;
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      held_q   <= held_q | cap;
      hval_q   <= (hval_q & ~cap) | (live & cap);
      status_q <= status_nxt;
      irq_q    <= |status_nxt;
    end
  end
endmodule

// File: rtl/gpio_pin_drv.sv
module gpio_pin_drv #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] out_val,
  input  logic [WIDTH-1:0] dir_in,
  input  logic             od_mode,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= '0;
      pin_oe  <= '0;
    end else if (od_mode) begin
      pin_out <= '0;
      pin_oe  <= ~dir_in & ~out_val;
    end else begin
      pin_out <= out_val;
      pin_oe  <= ~dir_in;
    end
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [WIDTH-1:0]  rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  output logic              irq_drive_low
);
  localparam logic [WIDTH-1:0] ZERO_W = '0;

  logic [WIDTH-1:0] out_q, pol_q, dir_q, pullen_q, pullsel_q;
  logic [WIDTH-1:0] drvl_q, drvh_q, latch_q, mask_q;
  logic             od_mode_q;
  logic [WIDTH-1:0] pin_sync, live, port_val, status_q;
  logic             ack;

  gpio_cfg_regs #(.WIDTH(WIDTH)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .out_q(out_q), .pol_q(pol_q), .dir_q(dir_q), .pullen_q(pullen_q),
    .pullsel_q(pullsel_q), .drvl_q(drvl_q), .drvh_q(drvh_q),
    .latch_q(latch_q), .mask_q(mask_q), .od_mode_q(od_mode_q)
  );

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_sync)
  );

  assign live = pin_sync ^ pol_q;
  assign ack  = rd_en && (addr == A_INPUT);

  gpio_irq_unit #(.WIDTH(WIDTH)) u_irq (
    .clk(clk), .rst(rst), .live(live), .mask(mask_q), .latch_en(latch_q),
    .ack(ack), .port_val(port_val), .status_q(status_q), .irq_q(irq_drive_low)
  );

  gpio_pin_drv #(.WIDTH(WIDTH)) u_drv (
    .clk(clk), .rst(rst), .out_val(out_q), .dir_in(dir_q),
    .od_mode(od_mode_q), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        A_INPUT:   rdata <= port_val;
        A_OUTPUT:  rdata <= out_q;
        A_POLAR:   rdata <= pol_q;
        A_DIR:     rdata <= dir_q;
        A_PULLEN:  rdata <= pullen_q;
        A_PULLSEL: rdata <= pullsel_q;
        A_DRVL:    rdata <= drvl_q;
        A_DRVH:    rdata <= drvh_q;
        A_LATCH:   rdata <= latch_q;
        A_MASK:    rdata <= mask_q;
        A_STATUS:  rdata <= status_q;
        A_MODE:    rdata <= {ZERO_W[WIDTH-1:1], od_mode_q};
        default:   rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [WIDTH-1:0]  rdata,
  input logic [WIDTH-1:0]  pin_out,
  input logic [WIDTH-1:0]  pin_oe,
  input logic              irq_drive_low,
  input logic [WIDTH-1:0]  status,
  input logic [WIDTH-1:0]  mask,
  input logic              od_mode,
  input logic [WIDTH-1:0]  held,
  input logic [WIDTH-1:0]  hval
);
  assert_reset_safe_R1: assert property (@(posedge clk)
    ($past(rst) && !rst) |-> (pin_oe == '0 && !irq_drive_low));

  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (status & ~$past(status) & $past(mask)) == '0);

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_INPUT) |=> (status == '0 && !irq_drive_low));

  assert_latch_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en && addr == A_INPUT) |-> ((held & $past(held) & (hval ^ $past(hval))) == '0));

  assert_od_never_high_R11: assert property (@(posedge clk) disable iff (rst)
    od_mode |=> ((pin_out & pin_oe) == '0));

  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

bind gpio_irq_port gpio_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .pin_out(pin_out), .pin_oe(pin_oe), .irq_drive_low(irq_drive_low),
  .status(u_irq.status_q), .mask(u_cfg.mask_q), .od_mode(u_cfg.od_mode_q),
  .held(u_irq.held_q), .hval(u_irq.hval_q)
);

// File: tb/tb_gpio_irq_port.sv
module tb_gpio_irq_port;
  localparam int W = 8;
  localparam int NV = 16;
  // {addr, write data, expected read}
  localparam logic [23:0] VEC [NV] = '{
    {8'd1,  8'hA5, 8'hA5}, {8'd2,  8'h0F, 8'h0F}, {8'd3,  8'h3C, 8'h3C},
    {8'd4,  8'h5A, 8'h5A}, {8'd5,  8'hC3, 8'hC3}, {8'd6,  8'h12, 8'h12},
    {8'd7,  8'h34, 8'h34}, {8'd8,  8'h81, 8'h81}, {8'd11, 8'hFF, 8'h01},
    {8'd10, 8'hFF, 8'h00}, {8'd14, 8'hFF, 8'h00}, {8'd2,  8'h00, 8'h00},
    {8'd3,  8'hFF, 8'hFF}, {8'd8,  8'h00, 8'h00}, {8'd11, 8'h00, 8'h00},
    {8'd9,  8'hFF, 8'hFF}
  };

  logic clk = 0, rst = 1, wr_en = 0, rd_en = 0;
  logic [3:0] addr = '0;
  logic [W-1:0] wdata = '0, pin_in = '0, rdata, pin_out, pin_oe, rv, hold;
  logic irq_drive_low;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_irq_port #(.WIDTH(W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq_drive_low(irq_drive_low)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [W-1:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    tick(4); rst = 0; tick(1);
    // R1 reset state
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 pin_out", pin_out, 8'h00);
    chk("R1 irq", {7'd0, irq_drive_low}, 8'h00);
    rd(4'd3, rv); chk("R1 dir", rv, 8'hFF);
    rd(4'd9, rv); chk("R1 mask", rv, 8'hFF);
    rd(4'd10, rv); chk("R1 status", rv, 8'h00);

    // R2 / R6 register table
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][19:16], VEC[i][15:8]);
      rd(VEC[i][19:16], rv);
      chk($sformatf("R2 vec %0d", i), rv, VEC[i][7:0]);
    end

    // R3 polarity, R5 masked changes
    pin_in = 8'h3C;
    wr(4'd2, 8'h0F); tick(3);
    rd(4'd0, rv); chk("R3 input xor pol", rv, 8'h33);
    rd(4'd10, rv); chk("R5 status masked", rv, 8'h00);
    chk("R5 irq masked", {7'd0, irq_drive_low}, 8'h00);
    wr(4'd2, 8'h00);
    rd(4'd0, rv); chk("R3 input no pol", rv, 8'h3C);

    // R4 latency, R6 status, R5 masked bit alongside
    wr(4'd9, 8'hFE);
    pin_in = 8'h3D;
    tick(2); chk("R4 irq not yet", {7'd0, irq_drive_low}, 8'h00);
    tick(1); chk("R4 irq third edge", {7'd0, irq_drive_low}, 8'h01);
    pin_in = 8'h3E; tick(4);
    rd(4'd10, rv); chk("R6 status source", rv, 8'h01);
    chk("R6 irq still pending", {7'd0, irq_drive_low}, 8'h01);
    pin_in = 8'h3F; tick(4);
    rd(4'd0, rv); chk("R7 input value", rv, 8'h3F);
    chk("R7 irq released", {7'd0, irq_drive_low}, 8'h00);
    rd(4'd10, rv); chk("R7 status cleared", rv, 8'h00);
    wr(4'd9, 8'hFF);

    // R8 latched bit 4, R9 unlatched bit 5
    wr(4'd8, 8'h10);
    pin_in = 8'h2F; tick(4);
    pin_in = 8'h3F; tick(4);
    rd(4'd0, rv); chk("R8 held value", rv, 8'h2F);
    rd(4'd0, rv); chk("R8 released", rv, 8'h3F);
    pin_in = 8'h1F; tick(4);
    pin_in = 8'h3F; tick(4);
    rd(4'd0, rv); chk("R9 live value", rv, 8'h3F);

    // R10 push-pull
    wr(4'd3, 8'h0F); wr(4'd1, 8'hA5); tick(1);
    chk("R10 oe", pin_oe, 8'hF0);
    chk("R10 out", pin_out, 8'hA5);
    // R11 open-drain
    wr(4'd11, 8'h01); tick(1);
    chk("R11 oe", pin_oe, 8'h50);
    chk("R11 out", pin_out, 8'h00);

    // R12 rdata holds without a read
    rd(4'd1, hold);
    wr(4'd1, 8'h3C); pin_in = 8'h00; tick(4);
    chk("R12 rdata stable", rdata, hold);

    done = 1;
    finish_run();
  end
endmodule